// File: doc/BRIEF.md
# Keyed Mode Unlock and Bank Select Controller

This block watches a byte-wide register bus (a small port address, separate read and write strobes, 8-bit write data) and decides which operating mode the surrounding device is in. Out of reset the device runs in its standard mode. It moves to the enhanced mode only after a fixed four-byte key is written, byte after byte, to the control port, with no other bus traffic in between. Anything else seen on the bus while the key is being entered throws the partial key away.

Once enhanced mode is reached, the control port changes its meaning. A write there picks one of three register banks from its two top bits and, in the same write, stores a four-bit polarity setting for the upper I/O ports from its low bits. A read of the control port reports only the bank, so the polarity setting cannot be read back. Every bank change therefore also rewrites the polarity bits. The device leaves enhanced mode only through the power-up reset or the software reset input.

Top module: `mode_bank_ctl`

## Requirements
- R1: The controller enters enhanced mode on the clock edge that takes the fourth of four consecutive writes to port 7 carrying 0x07, 0x0D, 0x06 and 0x12, in that order; `enh_mode` is high from that edge on.
- R2: While the key is being entered, a read or a write to any port other than 7 discards the key progress, and the whole key has to be written again. A read of port 7 neither advances nor discards it. Key bytes written to another port never count.
- R3: A write to port 7 that does not carry the next expected key byte discards the key progress. If that byte is 0x07, it counts as the first byte of a new key.
- R4: When `rst_n` is low or `soft_clr` is high at a clock edge, the controller goes to standard mode with bank 0, polarity 0 and no key progress after that edge. `soft_clr` wins over a bus write in the same cycle.
- R5: On entry to enhanced mode, `bank_sel` is 0.
- R6: In enhanced mode a write to port 7 sets the bank from data bits 7:6: 0b00 gives bank 0, 0b01 gives bank 1, 0b10 gives bank 2, and the reserved 0b11 gives bank 0.
- R7: The same enhanced-mode write loads data bits 3:0 into `pol_bits`. Data bits 5:4 are ignored. The polarity changes at no other time except reset.
- R8: `cfg_rdata` (the port 7 read data) is {bank_sel, 6'b0} in enhanced mode and 0x00 in standard mode. It never shows the polarity bits, and a read changes no state.
- R9: In standard mode, writes to port 7 never change `bank_sel` or `pol_bits`. In enhanced mode, key bytes act as ordinary bank writes, and the controller stays in enhanced mode until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| soft_clr | input | 1 | Synchronous active-high software reset |
| bus_addr | input | 3 | Port address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| enh_mode | output | 1 | High in enhanced mode |
| bank_sel | output | 2 | Selected register bank (0, 1 or 2) |
| pol_bits | output | 4 | Stored write-only polarity for the upper ports |
| cfg_rdata | output | 8 | Port 7 read data (bank status) |

## Verification
Two things can happen in the same cycle: the software reset and a port 7 write. The write may be the last key byte or a bank write. The bench drives `soft_clr` together with a bank write of 0x80 in enhanced mode, and separately together with the final key byte 0x12. In both cases it expects standard mode, bank 0 and polarity 0 after the edge. A behavioural reference model, compared on every clock, decides the same outcome independently, because it applies reset before it looks at the bus.

// File: rtl/mb_pkg.sv
// Shared constants and helpers for the keyed mode / bank controller.
// Assumes a fixed four-byte unlock key and a two-bit bank field.
package mb_pkg;
    localparam int KEY_LEN   = 4;
    localparam int KEY_IDX_W = $clog2(KEY_LEN);
    localparam int BANK_W    = 2;
    localparam int POL_W     = 4;

    typedef logic [KEY_IDX_W-1:0] key_idx_t;
    typedef logic [BANK_W-1:0]    bank_t;

    // Key byte expected at a given position of the unlock sequence.
    function automatic logic [7:0] key_at(key_idx_t idx);
        case (idx)
            2'd0:    key_at = 8'h07;
            2'd1:    key_at = 8'h0D;
            2'd2:    key_at = 8'h06;
            default: key_at = 8'h12;
        endcase
    endfunction

    // Map the raw bank field; the reserved code falls back to bank 0.
    function automatic bank_t decode_bank(logic [BANK_W-1:0] raw);
        decode_bank = (raw == 2'b11) ? bank_t'(0) : bank_t'(raw);
    endfunction
endpackage

// File: rtl/mb_key_tracker.sv
// Tracks progress through the unlock key and holds the mode flag.
// Assumes one bus access per cycle; any access to a port other than the
// control port discards progress; once unlocked, stays until a reset.
module mb_key_tracker
    import mb_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int CTRL_PORT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        wdata,
    output logic              enh_q,
    output logic              unlock
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_PORT);
    localparam key_idx_t LAST_IDX = key_idx_t'(KEY_LEN - 1);

    key_idx_t step_q, step_n;

    // Next key position and the one-cycle unlock strobe.
    always_comb begin
        step_n = step_q;
        unlock = 1'b0;
        if (!enh_q && (wr || rd)) begin
            if (addr != CTRL_A) begin
                step_n = '0;
            end else if (wr) begin
                if (wdata == key_at(step_q)) begin
                    if (step_q == LAST_IDX) begin
                        unlock = 1'b1;
                        step_n = '0;
                    end else begin
                        step_n = step_q + 1'b1;
                    end
                end else if (wdata == key_at('0)) begin
                    step_n = key_idx_t'(1);
                end else begin
                    step_n = '0;
                end
            end
        end
    end

    // Key position register, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) step_q <= '0;
        else               step_q <= step_n;
    end

    // Mode flag: set by a completed key, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) enh_q <= 1'b0;
        else if (unlock)   enh_q <= 1'b1;
    end
endmodule

// File: rtl/mb_bank_reg.sv
// Bank select and write-only polarity storage of the control port.
// Assumes load is asserted only for enhanced-mode writes to that port.
module mb_bank_reg
    import mb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             unlock,
    input  logic [BANK_W-1:0] sel_raw,
    input  logic [POL_W-1:0]  pol_in,
    output bank_t            bank_q,
    output logic [POL_W-1:0] pol_q
);
    // Bank register: zero on reset and on entry, decoded on a load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) bank_q <= '0;
        else if (unlock)   bank_q <= '0;
        else if (load)     bank_q <= decode_bank(sel_raw);
    end

    // Polarity register: rewritten by every control-port load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pol_q <= '0;
        else if (load)     pol_q <= pol_in;
    end
endmodule

// File: rtl/mb_status_view.sv
// Read view of the control port: bank status only, polarity hidden.
// Assumes the read data is sampled by the bus during a read strobe.
module mb_status_view
    import mb_pkg::*;
(
    input  logic       enh,
    input  bank_t      bank,
    output logic [7:0] rdata
);
    // Place the bank in the top bits; standard mode reads as zero.
    always_comb begin
        rdata = '0;
        if (enh) rdata[7:8-BANK_W] = bank;
    end
endmodule

// File: rtl/mode_bank_ctl.sv
// Top of the keyed mode / bank controller.
// Assumes a single-cycle bus access per strobe and synchronous resets.
module mode_bank_ctl
    import mb_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int CTRL_PORT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic              enh_mode,
    output logic [1:0]        bank_sel,
    output logic [3:0]        pol_bits,
    output logic [7:0]        cfg_rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_PORT);

    logic  unlock;
    logic  bank_load;
    bank_t bank_q;

    // Enhanced-mode write to the control port loads bank and polarity.
    always_comb bank_load = enh_mode && bus_wr && (bus_addr == CTRL_A);

    mb_key_tracker #(.ADDR_W(ADDR_W), .CTRL_PORT(CTRL_PORT)) u_key (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
        .enh_q(enh_mode), .unlock(unlock)
    );

    mb_bank_reg u_bank (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .load(bank_load), .unlock(unlock),
        .sel_raw(bus_wdata[7:8-BANK_W]), .pol_in(bus_wdata[POL_W-1:0]),
        .bank_q(bank_q), .pol_q(pol_bits)
    );

    mb_status_view u_view (
        .enh(enh_mode), .bank(bank_q), .rdata(cfg_rdata)
    );

    assign bank_sel = bank_q;
endmodule

// File: rtl/mode_bank_ctl_chk.sv
// Property checker for mode_bank_ctl, attached through bind below.
// Assumes synchronous active-low rst_n; observes the top's ports only.
module mode_bank_ctl_chk #(
    parameter int ADDR_W    = 3,
    parameter int CTRL_PORT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_clr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              enh_mode,
    input logic [1:0]        bank_sel,
    input logic [3:0]        pol_bits,
    input logic [7:0]        cfg_rdata
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_PORT);

    assert_entry_on_last_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enh_mode) |-> $past(bus_wr && bus_addr == CTRL_A && bus_wdata == 8'h12 && !soft_clr));

    assert_soft_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!enh_mode && bank_sel == 2'd0 && pol_bits == 4'd0));

    assert_entry_bank_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enh_mode) |-> bank_sel == 2'd0);

    assert_no_reserved_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel != 2'b11);

    assert_pol_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && !(enh_mode && bus_wr && bus_addr == CTRL_A)) |=> $stable(pol_bits));

    assert_status_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata == (enh_mode ? {bank_sel, 6'b0} : 8'h00));

    assert_std_no_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_mode |-> (bank_sel == 2'd0 && pol_bits == 4'd0));

    assert_mode_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_mode && !soft_clr) |=> enh_mode);
endmodule

bind mode_bank_ctl mode_bank_ctl_chk #(.ADDR_W(ADDR_W), .CTRL_PORT(CTRL_PORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .enh_mode(enh_mode),
    .bank_sel(bank_sel), .pol_bits(pol_bits), .cfg_rdata(cfg_rdata)
);

// File: tb/mode_bank_ctl_bench.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module mode_bank_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_clr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       enh_mode;
    logic [1:0] bank_sel;
    logic [3:0] pol_bits;
    logic [7:0] cfg_rdata;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    int m_enh = 0, m_step = 0, m_bank = 0, m_pol = 0;
    int keys[4] = '{8'h07, 8'h0D, 8'h06, 8'h12};

    mode_bank_ctl u_mode_bank_ctl (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .enh_mode(enh_mode), .bank_sel(bank_sel), .pol_bits(pol_bits),
        .cfg_rdata(cfg_rdata)
    );

    always #10 clk = ~clk;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // model update, reset applied before the bus is considered
    always @(posedge clk) begin
        cycles++;
        if (!rst_n || soft_clr) begin
            m_enh = 0; m_step = 0; m_bank = 0; m_pol = 0;
        end else if (m_enh == 0) begin
            if (bus_wr || bus_rd) begin
                if (bus_addr != 3'd7) m_step = 0;
                else if (bus_wr) begin
                    if (int'(bus_wdata) == keys[m_step]) begin
                        if (m_step == 3) begin m_enh = 1; m_step = 0; m_bank = 0; end
                        else m_step++;
                    end else m_step = (bus_wdata == 8'h07) ? 1 : 0;
                end
            end
        end else if (bus_wr && bus_addr == 3'd7) begin
            m_bank = (bus_wdata[7:6] == 2'b11) ? 0 : int'(bus_wdata[7:6]);
            m_pol  = int'(bus_wdata[3:0]);
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 mode", int'(enh_mode), m_enh);
            check("R6 bank", int'(bank_sel), m_bank);
            check("R7 pol", int'(pol_bits), m_pol);
            check("R8 rdata", int'(cfg_rdata), m_enh ? (m_bank << 6) : 0);
        end
    end

    always @(posedge clk) begin
        if (cycles >= 100000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic bus_wr_t(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_rd_t(input logic [2:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic sclr();
        @(negedge clk); soft_clr = 1'b1;
        @(negedge clk); soft_clr = 1'b0;
    endtask

    task automatic key(input int upto);
        for (int i = 0; i < upto; i++) bus_wr_t(3'd7, 8'(keys[i]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state
        check("R4 reset mode", int'(enh_mode), 0);
        check("R4 reset bank", int'(bank_sel), 0);
        check("R8 reset rdata", int'(cfg_rdata), 0);

        // R9: standard mode port 7 write touches no bank/polarity
        bus_wr_t(3'd7, 8'h4A);
        check("R9 std bank", int'(bank_sel), 0);
        check("R9 std pol", int'(pol_bits), 0);

        // R2: write to another port aborts
        key(3); bus_wr_t(3'd3, 8'h00); bus_wr_t(3'd7, 8'h12);
        check("R2 write abort", int'(enh_mode), 0);
        // R2: read of another port aborts
        key(2); bus_rd_t(3'd5); bus_wr_t(3'd7, 8'h06); bus_wr_t(3'd7, 8'h12);
        check("R2 read abort", int'(enh_mode), 0);
        // R2: key bytes to another port do not count
        sclr();
        for (int i = 0; i < 4; i++) bus_wr_t(3'd6, 8'(keys[i]));
        check("R2 other port key", int'(enh_mode), 0);
        // R3: wrong byte aborts
        sclr();
        key(2); bus_wr_t(3'd7, 8'h99); bus_wr_t(3'd7, 8'h06); bus_wr_t(3'd7, 8'h12);
        check("R3 wrong byte", int'(enh_mode), 0);
        // R3: wrong byte 0x07 restarts
        sclr();
        key(2); key(4);
        check("R3 restart", int'(enh_mode), 1);
        check("R5 entry bank", int'(bank_sel), 0);

        // R6/R7/R8 bank writes
        bus_wr_t(3'd7, 8'h4A);
        check("R6 bank1", int'(bank_sel), 1);
        check("R7 pol A", int'(pol_bits), 4'hA);
        check("R8 rdata bank1", int'(cfg_rdata), 8'h40);
        bus_wr_t(3'd7, 8'hB5);
        check("R6 bank2", int'(bank_sel), 2);
        check("R7 pol 5 ignore 5:4", int'(pol_bits), 4'h5);
        bus_wr_t(3'd7, 8'hC3);
        check("R6 reserved", int'(bank_sel), 0);
        check("R7 pol 3", int'(pol_bits), 4'h3);
        bus_wr_t(3'd7, 8'h8C);
        bus_rd_t(3'd7);
        check("R8 read no effect", int'(pol_bits), 4'hC);
        check("R8 rdata bank2", int'(cfg_rdata), 8'h80);
        bus_wr_t(3'd2, 8'h41);
        check("R7 other port", int'(pol_bits), 4'hC);
        // R9: key byte in enhanced mode is a bank write
        bus_wr_t(3'd7, 8'h07);
        check("R9 stays", int'(enh_mode), 1);
        check("R9 key as bank", int'(bank_sel), 0);
        check("R9 key as pol", int'(pol_bits), 4'h7);

        // R4: soft clear collides with a bank write
        @(negedge clk);
        soft_clr = 1'b1; bus_addr = 3'd7; bus_wdata = 8'h80; bus_wr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0; bus_wr = 1'b0;
        check("R4 clr vs write mode", int'(enh_mode), 0);
        check("R4 clr vs write bank", int'(bank_sel), 0);

        // R4: soft clear collides with the last key byte
        key(3);
        @(negedge clk);
        soft_clr = 1'b1; bus_addr = 3'd7; bus_wdata = 8'h12; bus_wr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0; bus_wr = 1'b0;
        check("R4 clr vs key", int'(enh_mode), 0);

        // R2: read of port 7 mid-key is neutral
        key(2); bus_rd_t(3'd7); bus_wr_t(3'd7, 8'h06); bus_wr_t(3'd7, 8'h12);
        check("R2 port7 read", int'(enh_mode), 1);
        check("R1 entered", int'(cfg_rdata), 8'h00);

        // R4: power-up reset
        bus_wr_t(3'd7, 8'h45);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R4 rst mode", int'(enh_mode), 0);
        check("R4 rst pol", int'(pol_bits), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule